// File: doc/BRIEF.md
# Auto-Incrementing Host Memory Port

This block sits between an 8-bit host processor bus and a video memory that belongs to a display controller. The host sets up a 14-bit memory address by writing two bytes to a control port. It then moves bytes through a data port. Every completed transfer advances the address by one, and the address wraps at the top of the 16K space.

Reads never make the host wait on memory. When the host reads the data port, it gets the contents of a read buffer at once. The port then fetches the following location into that buffer. A read setup fills the buffer from the freshly loaded address.

Memory requests go to an arbiter that gives display fetches precedence. A request is held steady until the arbiter grants it. While a request waits, a busy output is high, and the port ignores host strobes.

Top module: `vmem_host_port`

## Requirements
- R1: The address is loaded by two control-port writes (`host_sel`=1). The first byte is the low 8 address bits. The second byte supplies address bits 13:8 in its bits 5:0, and its bit 6 picks the setup kind: 1 = write setup, 0 = read setup. If bit 7 of the second byte is 1, the pair completes but the address and setup are unchanged.
- R2: A read setup to address A fetches byte A into the read buffer. Afterwards the address is A+1.
- R3: A data-port read (`host_sel`=0) returns the read buffer on `host_rdata`. The port then fetches the byte at the current address into the buffer and increments the address. Successive reads therefore return consecutive bytes.
- R4: A data-port write stores the byte at the current address and then increments the address.
- R5: The address wraps from 0x3FFF to 0x0000.
- R6: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are held unchanged from the first request cycle until the cycle `mem_gnt` is high. A write or fetch takes effect only in that cycle.
- R7: `busy` is high from the cycle after an accepted data access or read setup until the cycle in which the arbiter grants the request.
- R8: Host strobes that arrive while `busy` is high have no effect.
- R9: Any accepted data-port access clears the control-byte toggle, so the next control write is taken as a low byte.
- R10: After reset the address is 0, the toggle is clear, `host_rdata` is 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 1 = control port, 0 = data port |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read buffer contents |
| busy | output | 1 | A memory request is waiting for a grant |
| mem_req | output | 1 | Memory request to the arbiter |
| mem_we | output | 1 | 1 = write request, 0 = fetch |
| mem_addr | output | 14 | Memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Fetched byte, valid in the grant cycle |
| mem_gnt | input | 1 | Arbiter grant |

## Verification
The hardest case to reach from the ports is a stalled request that meets fresh host traffic. The stimulus has to hold off the grant long enough that a data write and a control byte arrive while the port is still busy. The bench does this with an arbiter model whose display-priority window is counted down by the bench. After the grant, memory contents and the address taken by the next write show that the stray strobes were dropped. Address-wrap sweeps start a few bytes below 0x3FFF, in both the read and the write direction.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
   typedef enum logic {
      SETUP_READ  = 1'b0,
      SETUP_WRITE = 1'b1
   } setup_e;

   localparam int KIND_BIT = 6;
   localparam int SKIP_BIT = 7;
endpackage

// File: rtl/vhp_addr_loader.sv
module vhp_addr_loader
   import vhp_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              data_acc,
   input  logic [7:0]        wbyte,
   output logic              load_vld,
   output logic [ADDR_W-1:0] load_addr,
   output setup_e            load_kind,
   output logic              toggle_o
);
   localparam int HI_W = ADDR_W - 8;

   logic       toggle_q;
   logic [7:0] lo_q;

   generate
      if (ADDR_W < 8 || ADDR_W > 14) begin : g_bad_width
         $error("vhp_addr_loader: ADDR_W must lie in 8..14");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         toggle_q <= 1'b0;
         lo_q     <= '0;
      end else if (ctl_wr) begin
         if (!toggle_q) lo_q <= wbyte;
         toggle_q <= ~toggle_q;
      end else if (data_acc) begin
         toggle_q <= 1'b0;
      end
   end

   generate
      if (HI_W > 0) begin : g_hi
         assign load_addr = {wbyte[HI_W-1:0], lo_q};
      end else begin : g_lo_only
         assign load_addr = lo_q[ADDR_W-1:0];
      end
   endgenerate

   assign load_vld  = ctl_wr && toggle_q && !wbyte[SKIP_BIT];
   assign load_kind = setup_e'(wbyte[KIND_BIT]);
   assign toggle_o  = toggle_q;

   // R9
   toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !ctl_wr) |=> !toggle_q);

   // R1
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (toggle_q != $past(toggle_q)));
endmodule

// File: rtl/vhp_addr_counter.sv
module vhp_addr_counter #(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= load_val;
      else if (inc)  addr_q <= addr_q + 1'b1;
   end

   assign addr_o = addr_q;

   // R5
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && addr_q == TOP) |=> (addr_q == '0));

   // R4
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> (addr_q == $past(addr_q) + 1'b1));

   // R2
   load_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && inc));
endmodule

// File: rtl/vhp_xfer_seq.sv
module vhp_xfer_seq #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rd,
   input  logic              start_wr,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              req,
   output logic              we,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rbuf,
   output logic              done
);
   logic              pend_rd_q, pend_wr_q;
   logic [DATA_W-1:0] wbuf_q, rbuf_q;

   assign req  = pend_rd_q | pend_wr_q;
   assign done = req && gnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_rd_q <= 1'b0;
         pend_wr_q <= 1'b0;
         wbuf_q    <= '0;
         rbuf_q    <= '0;
      end else if (done) begin
         if (pend_rd_q) rbuf_q <= mem_rdata;
         pend_rd_q <= 1'b0;
         pend_wr_q <= 1'b0;
      end else if (!req) begin
         if (start_wr) begin
            pend_wr_q <= 1'b1;
            wbuf_q    <= wr_byte;
         end else if (start_rd) begin
            pend_rd_q <= 1'b1;
         end
      end
   end

   assign we    = pend_wr_q;
   assign wdata = wbuf_q;
   assign rbuf  = rbuf_q;

   // R6
   single_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pend_rd_q, pend_wr_q}));

   // R6
   hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !gnt) |=> (req && $stable(we) && $stable(wdata)));

   // R3
   rbuf_only_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && gnt && !we) |=> $stable(rbuf_q));
endmodule

// File: rtl/vmem_host_port.sv
module vmem_host_port
   import vhp_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_gnt
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("vmem_host_port: DATA_W must be 8");
      end
   endgenerate

   logic              acc_ok, ctl_wr, d_wr, d_rd, d_acc;
   logic              load_vld, toggle;
   logic [ADDR_W-1:0] load_addr, addr;
   setup_e            load_kind;
   logic              start_rd, done, req;

   assign acc_ok = !req;
   assign ctl_wr = acc_ok && host_sel && host_wr;
   assign d_wr   = acc_ok && !host_sel && host_wr;
   assign d_rd   = acc_ok && !host_sel && host_rd && !host_wr;
   assign d_acc  = d_wr || d_rd;

   vhp_addr_loader #(.ADDR_W(ADDR_W)) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .data_acc  (d_acc),
      .wbyte     (host_wdata),
      .load_vld  (load_vld),
      .load_addr (load_addr),
      .load_kind (load_kind),
      .toggle_o  (toggle)
   );

   vhp_addr_counter #(.ADDR_W(ADDR_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_vld),
      .load_val (load_addr),
      .inc      (done),
      .addr_o   (addr)
   );

   assign start_rd = d_rd || (load_vld && load_kind == SETUP_READ);

   vhp_xfer_seq #(.DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_rd  (start_rd),
      .start_wr  (d_wr),
      .wr_byte   (host_wdata),
      .gnt       (mem_gnt),
      .mem_rdata (mem_rdata),
      .req       (req),
      .we        (mem_we),
      .wdata     (mem_wdata),
      .rbuf      (host_rdata),
      .done      (done)
   );

   assign mem_req  = req;
   assign mem_addr = addr;
   assign busy     = req;

   // R3
   prefetch_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_rd |=> (mem_req && !mem_we));

   // R8
   busy_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_wr && !mem_gnt) |=> ($stable(mem_wdata) && $stable(toggle)));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> $stable(mem_addr));

   // R7
   busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> !busy);
endmodule

// File: tb/vmem_host_port_bench.sv
module vmem_host_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        busy, mem_req, mem_we, mem_gnt;
   logic [13:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   logic [7:0]  vram [16384];
   int          disp_hold = 0;
   bit          slow_arb = 1'b0;
   int          cyc = 0;
   int          n_run = 0, n_fail = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   vmem_host_port u_vmem_host_port (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
   );

   // arbiter model: display window blocks grants
   assign mem_gnt   = mem_req && (disp_hold == 0) && !(slow_arb && (cyc % 3 != 0));
   assign mem_rdata = vram[mem_addr];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (disp_hold > 0) disp_hold <= disp_hold - 1;
      if (mem_req && mem_gnt && mem_we) vram[mem_addr] <= mem_wdata;
      if (cyc > 100000 && !finished) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, got cycle %0d expected < 100000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run = n_run + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic strobe(input bit sel, input bit wr, input logic [7:0] b);
      @(negedge clk);
      host_sel = sel; host_wr = wr; host_rd = !wr; host_wdata = b;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic set_addr(input logic [13:0] a, input bit wflag);
      strobe(1'b1, 1'b1, a[7:0]);
      strobe(1'b1, 1'b1, {1'b0, wflag, a[13:8]});
      wait_idle();
   endtask

   task automatic data_wr(input logic [7:0] b);
      strobe(1'b0, 1'b1, b);
      wait_idle();
   endtask

   task automatic data_rd(output logic [7:0] v);
      @(negedge clk);
      v = host_rdata;
      strobe(1'b0, 1'b0, 8'h00);
      wait_idle();
   endtask

   initial begin
      logic [7:0]  v, old;
      logic [13:0] bases [3];
      int          busy_cycles;

      for (int i = 0; i < 16384; i++) vram[i] = 8'((i * 37) + (i >> 6));
      repeat (3) @(negedge clk);
      // R10 reset state
      check(busy == 1'b0, "R10 busy", busy, 0);
      check(mem_req == 1'b0, "R10 mem_req", mem_req, 0);
      check(host_rdata == 8'h00, "R10 rdata", host_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_addr == 14'h0, "R10 address", mem_addr, 0);

      // R1 R4 R5 write sweeps, fast then slow arbiter
      bases[0] = 14'h0000; bases[1] = 14'h1234; bases[2] = 14'h3FFC;
      for (int s = 0; s < 2; s++) begin
         slow_arb = (s == 1);
         for (int b = 0; b < 3; b++) begin
            set_addr(bases[b] + 14'(s * 16), 1'b1);
            for (int i = 0; i < 8; i++) data_wr(8'(8'hA0 + i * 3 + b + s * 50));
            for (int i = 0; i < 8; i++) begin
               logic [13:0] a;
               a = bases[b] + 14'(s * 16) + 14'(i);
               check(vram[a] == 8'(8'hA0 + i * 3 + b + s * 50),
                     (a < bases[b]) ? "R5 write wrap" : "R4 write", vram[a],
                     8'(8'hA0 + i * 3 + b + s * 50));
            end
         end
      end

      // R2 R3 R5 read sweeps
      bases[0] = 14'h0005; bases[1] = 14'h2AAA; bases[2] = 14'h3FFD;
      for (int s = 0; s < 2; s++) begin
         slow_arb = (s == 1);
         for (int b = 0; b < 3; b++) begin
            set_addr(bases[b], 1'b0);
            check(host_rdata == vram[bases[b]], "R2 read setup prefetch",
                  host_rdata, vram[bases[b]]);
            for (int i = 0; i < 6; i++) begin
               logic [13:0] a;
               a = bases[b] + 14'(i);
               data_rd(v);
               check(v == vram[a], (a < bases[b]) ? "R5 read wrap" : "R3 read",
                     v, vram[a]);
            end
         end
      end
      slow_arb = 1'b0;

      // R6 R7 R8 long display window
      set_addr(14'h0100, 1'b1);
      old = vram[14'h0101];
      disp_hold = 20;
      strobe(1'b0, 1'b1, 8'hAA);
      check(busy == 1'b1 && mem_req == 1'b1, "R7 busy raised", busy, 1);
      strobe(1'b0, 1'b1, 8'h55);
      strobe(1'b1, 1'b1, 8'h77);
      check(mem_addr == 14'h0100 && mem_wdata == 8'hAA, "R6 held request",
            mem_wdata, 8'hAA);
      busy_cycles = 0;
      while (busy) begin busy_cycles++; @(negedge clk); end
      check(busy_cycles >= 12, "R7 busy through stall", busy_cycles, 12);
      check(vram[14'h0100] == 8'hAA, "R6 write after grant", vram[14'h0100], 8'hAA);
      check(vram[14'h0101] == old, "R8 stray write dropped", vram[14'h0101], old);
      data_wr(8'h3C);
      check(vram[14'h0101] == 8'h3C, "R8 stray control dropped",
            vram[14'h0101], 8'h3C);

      // R9 toggle cleared by data access
      strobe(1'b1, 1'b1, 8'h40);
      data_rd(v);
      set_addr(14'h0200, 1'b1);
      data_wr(8'h99);
      check(vram[14'h0200] == 8'h99, "R9 toggle clear", vram[14'h0200], 8'h99);

      // R1 second byte with bit 7 set leaves address alone
      set_addr(14'h0300, 1'b1);
      strobe(1'b1, 1'b1, 8'h00);
      strobe(1'b1, 1'b1, 8'hC5);
      data_wr(8'h5A);
      check(vram[14'h0300] == 8'h5A, "R1 skip byte", vram[14'h0300], 8'h5A);
      set_addr(14'h0301, 1'b0);
      check(host_rdata == vram[14'h0301], "R1 kind bit read", host_rdata,
            vram[14'h0301]);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule